// File: doc/BRIEF.md
# Masked Broadcast SIMD Processing Array

A grid of processing elements laid out in `ROWS` by `COLS` that all take the same instruction from one shared issue port in every cycle. Each element has its own 64-bit accumulator, a private word-addressed memory and an enable flag. Only enabled elements change their accumulator or memory. Each word can be handled as one 64-bit value, as two 32-bit lanes or as eight 8-bit lanes. The issuing controller can place one operand on a common bus that every element reads in the same cycle. It can also pull one word out of any single element's memory into a scalar result register.

Vector data is laid out one item per element: element `i = row*COLS + col` holds item `i`. Elements exchange accumulators with their four grid neighbours in one cycle. The grid wraps at every edge, so it is a torus. The memory depth is a parameter. Full size is 2048 words; the default build uses a smaller depth to keep elaboration small. The issue path has a fixed two-edge latency and accepts a new instruction every cycle.

Top module: `simd_array`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, every accumulator reads 0, every enable flag reads 1 and `scalar_valid` reads 0.
- R2: An instruction sampled with `instr_valid` high at clock edge k shows its effect on the outputs after edge k+2. A new instruction may be issued on every edge. When `instr_valid` is low, the other issue inputs have no effect.
- R3: For opcodes 1 to 11, 14 and 16, an element whose enable flag is 0 changes neither its accumulator nor its memory.
- R4: ADD (opcode 1) and SUB (opcode 2) set acc to acc plus or minus mem[addr], split into lanes by `fmt`: 0 = one 64-bit lane, 1 = two 32-bit lanes, 2 = eight 8-bit lanes, any other code = 64-bit. No carry or borrow crosses a lane boundary.
- R5: AND (3), OR (4) and XOR (5) combine acc bitwise with mem[addr].
- R6: LOAD (6) copies mem[addr] into acc. STORE (7) writes acc into mem[addr]. Each element's memory is private. A read issued two or more cycles after a store sees the stored word.
- R7: BCAST (14) copies `bcast_data` into acc. INDEX (16) sets acc to the element's own number, row*COLS+col.
- R8: Route opcodes move every accumulator one step at the same time, wrapping at the grid edges. Opcode 8 moves to row-1, 9 to row+1, 10 to col+1 and 11 to col-1.
- R9: During a route, a disabled element still supplies its accumulator to its neighbour but keeps its own value.
- R10: ZTEST (12) leaves an element enabled only if it was enabled and its full 64-bit acc is 0. ENALL (13) enables every element. A flag goes from 0 to 1 only through ENALL.
- R11: FETCH (15) loads mem[addr] of element `fetch_sel` into `scalar_reg`, whatever that element's flag is. A value of `fetch_sel` that is N or more gives 0. `scalar_valid` is high for exactly that one cycle, and `scalar_reg` holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Issue strobe |
| opcode | input | 5 | Operation code |
| fmt | input | 3 | Lane format |
| addr | input | AW | Local memory word address |
| bcast_data | input | 64 | Common-bus operand |
| fetch_sel | input | IDXW | Element chosen by FETCH |
| acc_flat | output | N*64 | Accumulators, element i at bits [64i+63:64i] |
| active_flat | output | N | Enable flags, element i at bit i |
| scalar_reg | output | 64 | Fetched scalar |
| scalar_valid | output | 1 | Pulses when scalar_reg is loaded |

## Verification
The bench uses a 2x3 grid, so row wrap and column wrap take different paths. It runs each route once, including back-to-back routes. A neighbour map that did not wrap, or that mixed up row and column, would leave edge elements with the wrong values. Packed adds and subtracts are run on operands chosen so that a carry or borrow would cross every lane boundary; a design that leaked carries would corrupt the next lane. The masking tests enable only some elements and then broadcast, store and route. A design that let disabled elements write, or that stopped them forwarding during a route, would show unexpected accumulators. Fetches from a disabled element and from an out-of-range index check that the scalar path ignores the enable flags and does not return a stale or wrapped word.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int WORD_W    = 64;
  localparam int LANE_W    = 8;
  localparam int NUM_BYTES = WORD_W / LANE_W;

  typedef enum logic [4:0] {
    OP_NOP    = 5'd0,
    OP_ADD    = 5'd1,
    OP_SUB    = 5'd2,
    OP_AND    = 5'd3,
    OP_OR     = 5'd4,
    OP_XOR    = 5'd5,
    OP_LOAD   = 5'd6,
    OP_STORE  = 5'd7,
    OP_RTN    = 5'd8,
    OP_RTS    = 5'd9,
    OP_RTE    = 5'd10,
    OP_RTW    = 5'd11,
    OP_ZTEST  = 5'd12,
    OP_ENALL  = 5'd13,
    OP_BCAST  = 5'd14,
    OP_FETCH  = 5'd15,
    OP_INDEX  = 5'd16
  } op_e;

  localparam logic [2:0] FMT_W64 = 3'd0;
  localparam logic [2:0] FMT_W32 = 3'd1;
  localparam logic [2:0] FMT_W8  = 3'd2;

  // True when byte b opens a new lane for the given format
  function automatic logic lane_start(input logic [2:0] f, input int b);
    if (b == 0)                             return 1'b1;
    if (f == FMT_W8)                        return 1'b1;
    if (f == FMT_W32 && b == NUM_BYTES / 2) return 1'b1;
    return 1'b0;
  endfunction
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
(
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  op_e               op,
  input  logic [2:0]        fmt,
  output logic [WORD_W-1:0] y
);
  logic              is_sub;
  logic [WORD_W-1:0] b_eff;
  logic [WORD_W-1:0] sum;
  logic [NUM_BYTES-1:0] cin;
  logic [NUM_BYTES-2:0] cout;

  assign is_sub = (op == OP_SUB);
  assign b_eff  = is_sub ? ~b : b;

  // Byte-sliced adder; the chain is cut at each lane boundary
  for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
    if (gi == 0) begin : g_first
      assign cin[gi] = is_sub;
    end else begin : g_next
      assign cin[gi] = lane_start(fmt, gi) ? is_sub : cout[gi-1];
    end
    if (gi < NUM_BYTES - 1) begin : g_carry
      assign {cout[gi], sum[gi*LANE_W +: LANE_W]} =
        {1'b0, a[gi*LANE_W +: LANE_W]} + {1'b0, b_eff[gi*LANE_W +: LANE_W]} +
        {{LANE_W{1'b0}}, cin[gi]};
    end else begin : g_top
      assign sum[gi*LANE_W +: LANE_W] =
        a[gi*LANE_W +: LANE_W] + b_eff[gi*LANE_W +: LANE_W] +
        {{(LANE_W-1){1'b0}}, cin[gi]};
    end
  end

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: y = sum;
      OP_AND:         y = a & b;
      OP_OR:          y = a | b;
      OP_XOR:         y = a ^ b;
      default:        y = a;
    endcase
  end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int AW     = 9,
  parameter int DEPTH  = 512,
  parameter int PE_IDX = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     rd_addr,
  input  logic              s1_vld,
  input  op_e               s1_op,
  input  logic [2:0]        s1_fmt,
  input  logic [AW-1:0]     s1_addr,
  input  logic [WORD_W-1:0] s1_data,
  input  logic [WORD_W-1:0] from_n,
  input  logic [WORD_W-1:0] from_s,
  input  logic [WORD_W-1:0] from_e,
  input  logic [WORD_W-1:0] from_w,
  output logic [WORD_W-1:0] acc_q,
  output logic              active_q,
  output logic [WORD_W-1:0] rd_q
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic              we;
  logic [WORD_W-1:0] alu_y;
  logic [WORD_W-1:0] acc_nxt;
  logic              act_nxt;

  simd_lane_alu u_alu (
    .a   (acc_q),
    .b   (rd_q),
    .op  (s1_op),
    .fmt (s1_fmt),
    .y   (alu_y)
  );

  assign we = s1_vld && active_q && (s1_op == OP_STORE);

  always_comb begin
    acc_nxt = acc_q;
    act_nxt = active_q;
    if (s1_vld) begin
      if (active_q) begin
        case (s1_op)
          OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: acc_nxt = alu_y;
          OP_LOAD:  acc_nxt = rd_q;
          OP_RTN:   acc_nxt = from_s;
          OP_RTS:   acc_nxt = from_n;
          OP_RTE:   acc_nxt = from_w;
          OP_RTW:   acc_nxt = from_e;
          OP_BCAST: acc_nxt = s1_data;
          OP_INDEX: acc_nxt = WORD_W'(PE_IDX);
          OP_ZTEST: act_nxt = (acc_q == '0);
          default:  ;
        endcase
      end
      if (s1_op == OP_ENALL) act_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      active_q <= 1'b1;
    end else begin
      acc_q    <= acc_nxt;
      active_q <= act_nxt;
    end
  end

  // Single-port style memory: registered read, no reset on the array
  always_ff @(posedge clk) begin
    if (we) mem[s1_addr] <= acc_q;
    rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
#(
  parameter int N    = 4,
  parameter int AW   = 9,
  parameter int IDXW = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_vld,
  input  logic [4:0]          in_op,
  input  logic [2:0]          in_fmt,
  input  logic [AW-1:0]       in_addr,
  input  logic [WORD_W-1:0]   in_data,
  input  logic [IDXW-1:0]     in_sel,
  input  logic [N*WORD_W-1:0] rd_flat,
  output logic                s1_vld,
  output op_e                 s1_op,
  output logic [2:0]          s1_fmt,
  output logic [AW-1:0]       s1_addr,
  output logic [WORD_W-1:0]   s1_data,
  output logic [WORD_W-1:0]   scalar_q,
  output logic                scalar_vld_q
);
  logic [IDXW-1:0]   s1_sel;
  logic [WORD_W-1:0] fetch_word;
  logic              fetch_go;

  always_comb begin
    fetch_word = '0;
    for (int i = 0; i < N; i++) begin
      if (int'(s1_sel) == i) fetch_word = rd_flat[i*WORD_W +: WORD_W];
    end
  end

  assign fetch_go = s1_vld && (s1_op == OP_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld       <= 1'b0;
      s1_op        <= OP_NOP;
      s1_fmt       <= FMT_W64;
      s1_addr      <= '0;
      s1_data      <= '0;
      s1_sel       <= '0;
      scalar_q     <= '0;
      scalar_vld_q <= 1'b0;
    end else begin
      s1_vld       <= in_vld;
      s1_op        <= op_e'(in_op);
      s1_fmt       <= in_fmt;
      s1_addr      <= in_addr;
      s1_data      <= in_data;
      s1_sel       <= in_sel;
      scalar_vld_q <= fetch_go;
      if (fetch_go) scalar_q <= fetch_word;
    end
  end
endmodule

// File: rtl/simd_array.sv
module simd_array
  import simd_pkg::*;
#(
  parameter int ROWS      = 2,
  parameter int COLS      = 2,
  parameter int MEM_DEPTH = 512,
  localparam int N    = ROWS * COLS,
  localparam int AW   = $clog2(MEM_DEPTH),
  localparam int IDXW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                instr_valid,
  input  logic [4:0]          opcode,
  input  logic [2:0]          fmt,
  input  logic [AW-1:0]       addr,
  input  logic [WORD_W-1:0]   bcast_data,
  input  logic [IDXW-1:0]     fetch_sel,
  output logic [N*WORD_W-1:0] acc_flat,
  output logic [N-1:0]        active_flat,
  output logic [WORD_W-1:0]   scalar_reg,
  output logic                scalar_valid
);
  logic              s1_vld;
  op_e               s1_op;
  logic [2:0]        s1_fmt;
  logic [AW-1:0]     s1_addr;
  logic [WORD_W-1:0] s1_data;
  logic [WORD_W-1:0] acc_arr [N];
  logic [N*WORD_W-1:0] rd_flat;

  simd_ctrl #(.N(N), .AW(AW), .IDXW(IDXW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .in_vld       (instr_valid),
    .in_op        (opcode),
    .in_fmt       (fmt),
    .in_addr      (addr),
    .in_data      (bcast_data),
    .in_sel       (fetch_sel),
    .rd_flat      (rd_flat),
    .s1_vld       (s1_vld),
    .s1_op        (s1_op),
    .s1_fmt       (s1_fmt),
    .s1_addr      (s1_addr),
    .s1_data      (s1_data),
    .scalar_q     (scalar_reg),
    .scalar_vld_q (scalar_valid)
  );

  for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
    for (genvar gc = 0; gc < COLS; gc++) begin : g_col
      localparam int I  = gr * COLS + gc;
      localparam int NI = ((gr + ROWS - 1) % ROWS) * COLS + gc;
      localparam int SI = ((gr + 1) % ROWS) * COLS + gc;
      localparam int WI = gr * COLS + (gc + COLS - 1) % COLS;
      localparam int EI = gr * COLS + (gc + 1) % COLS;

      simd_pe #(.AW(AW), .DEPTH(MEM_DEPTH), .PE_IDX(I)) u_pe (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (addr),
        .s1_vld   (s1_vld),
        .s1_op    (s1_op),
        .s1_fmt   (s1_fmt),
        .s1_addr  (s1_addr),
        .s1_data  (s1_data),
        .from_n   (acc_arr[NI]),
        .from_s   (acc_arr[SI]),
        .from_e   (acc_arr[EI]),
        .from_w   (acc_arr[WI]),
        .acc_q    (acc_arr[I]),
        .active_q (active_flat[I]),
        .rd_q     (rd_flat[I*WORD_W +: WORD_W])
      );

      assign acc_flat[I*WORD_W +: WORD_W] = acc_arr[I];
    end
  end
endmodule

// File: rtl/simd_array_chk.sv
module simd_array_chk
  import simd_pkg::*;
#(
  parameter int N = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                instr_valid,
  input logic [4:0]          opcode,
  input logic [N*WORD_W-1:0] acc_flat,
  input logic [N-1:0]        active_flat,
  input logic [WORD_W-1:0]   scalar_reg,
  input logic                scalar_valid
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (active_flat == '1 && acc_flat == '0 && !scalar_valid));

  // R11
  scalar_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    scalar_valid |-> $past(instr_valid && opcode == OP_FETCH, 2));

  // R11
  scalar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !scalar_valid |-> $stable(scalar_reg));

  for (genvar gi = 0; gi < N; gi++) begin : g_el
    // R3
    masked_acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(active_flat[gi]) |-> $stable(acc_flat[gi*WORD_W +: WORD_W]));

    // R10
    enable_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(active_flat[gi]) |-> $past(instr_valid && opcode == OP_ENALL, 2));
  end
endmodule

bind simd_array simd_array_chk #(.N(ROWS * COLS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .instr_valid  (instr_valid),
  .opcode       (opcode),
  .acc_flat     (acc_flat),
  .active_flat  (active_flat),
  .scalar_reg   (scalar_reg),
  .scalar_valid (scalar_valid)
);

// File: tb/simd_array_tb.sv
module simd_array_tb;
  localparam int R     = 2;
  localparam int C     = 3;
  localparam int N     = R * C;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int IDXW  = $clog2(N);

  localparam logic [4:0] ADD = 1, SUB = 2, AND_ = 3, OR_ = 4, XOR_ = 5, LOAD = 6,
    STORE = 7, RTN = 8, RTS = 9, RTE = 10, RTW = 11, ZTEST = 12, ENALL = 13,
    BCAST = 14, FETCH = 15, INDEX = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_valid = 1'b0;
  logic [4:0] opcode = '0;
  logic [2:0] fmt = '0;
  logic [AW-1:0] addr = '0;
  logic [63:0] bcast_data = '0;
  logic [IDXW-1:0] fetch_sel = '0;
  logic [N*64-1:0] acc_flat;
  logic [N-1:0] active_flat;
  logic [63:0] scalar_reg;
  logic scalar_valid;

  simd_array #(.ROWS(R), .COLS(C), .MEM_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .opcode(opcode), .fmt(fmt),
    .addr(addr), .bcast_data(bcast_data), .fetch_sel(fetch_sel),
    .acc_flat(acc_flat), .active_flat(active_flat),
    .scalar_reg(scalar_reg), .scalar_valid(scalar_valid)
  );

  always #4ns clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    int              due;
    string           tag;
    logic [N*64-1:0] acc;
    logic [N-1:0]    act;
    bit              fch;
    logic [63:0]     sc;
  } exp_t;
  exp_t q[$];

  logic [63:0] m_acc [N];
  bit          m_act [N];
  logic [63:0] m_mem [N][DEPTH];
  logic [63:0] m_sc = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] lanes(input logic [63:0] x, input logic [63:0] y,
                                        input bit sub, input logic [2:0] f);
    int w = (f == 3'd1) ? 32 : (f == 3'd2) ? 8 : 64;
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] r = '0;
    for (int j = 0; j < 64 / w; j++) begin
      logic [63:0] p = (x >> (j * w)) & m;
      logic [63:0] v = (y >> (j * w)) & m;
      logic [63:0] z = (sub ? p - v : p + v) & m;
      r |= z << (j * w);
    end
    return r;
  endfunction

  task automatic push_exp(input string tag, input bit fch);
    exp_t e;
    e.due = cyc + 2;
    e.tag = tag;
    e.fch = fch;
    e.sc  = m_sc;
    for (int i = 0; i < N; i++) begin
      e.acc[i*64 +: 64] = m_acc[i];
      e.act[i] = m_act[i];
    end
    q.push_back(e);
  endtask

  task automatic issue(input logic [4:0] op, input logic [2:0] f, input int a,
                       input logic [63:0] d, input int sel, input string tag);
    logic [63:0] old [N];
    @(negedge clk);
    instr_valid = 1'b1; opcode = op; fmt = f; addr = AW'(a);
    bcast_data = d; fetch_sel = IDXW'(sel);
    old = m_acc;
    for (int e = 0; e < N; e++) begin
      int r = e / C;
      int c = e % C;
      if (m_act[e]) begin
        case (op)
          ADD:   m_acc[e] = lanes(old[e], m_mem[e][a], 1'b0, f);
          SUB:   m_acc[e] = lanes(old[e], m_mem[e][a], 1'b1, f);
          AND_:  m_acc[e] = old[e] & m_mem[e][a];
          OR_:   m_acc[e] = old[e] | m_mem[e][a];
          XOR_:  m_acc[e] = old[e] ^ m_mem[e][a];
          LOAD:  m_acc[e] = m_mem[e][a];
          STORE: m_mem[e][a] = old[e];
          RTN:   m_acc[e] = old[((r + 1) % R) * C + c];
          RTS:   m_acc[e] = old[((r + R - 1) % R) * C + c];
          RTE:   m_acc[e] = old[r * C + (c + C - 1) % C];
          RTW:   m_acc[e] = old[r * C + (c + 1) % C];
          ZTEST: m_act[e] = (old[e] == 64'd0);
          BCAST: m_acc[e] = d;
          INDEX: m_acc[e] = 64'(e);
          default: ;
        endcase
      end
      if (op == ENALL) m_act[e] = 1'b1;
    end
    if (op == FETCH) m_sc = (sel < N) ? m_mem[sel][a] : 64'd0;
    push_exp(tag, op == FETCH);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      instr_valid = 1'b0;
    end
  endtask

  // Inputs toggle with the strobe low: nothing may change (R2)
  task automatic ghost();
    @(negedge clk);
    instr_valid = 1'b0; opcode = BCAST; bcast_data = 64'hDEAD_BEEF_0BAD_F00D;
    push_exp("R2 strobe low", 1'b0);
  endtask

  // Monitor: pops the expected item due this cycle
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      for (int i = 0; i < N; i++)
        chk(acc_flat[i*64 +: 64] === e.acc[i*64 +: 64], e.tag,
            acc_flat[i*64 +: 64], e.acc[i*64 +: 64]);
      chk(active_flat === e.act, {e.tag, " flags"}, 64'(active_flat), 64'(e.act));
      chk(scalar_valid === e.fch, {e.tag, " R11 valid"}, 64'(scalar_valid), 64'(e.fch));
      if (e.fch) chk(scalar_reg === e.sc, {e.tag, " R11 scalar"}, scalar_reg, e.sc);
    end
  end

  initial begin
    #(8ns * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [63:0] P = 64'h00FF_7FFF_FFFF_FF80;
  localparam logic [63:0] Q = 64'h0001_0001_0000_0081;

  initial begin
    for (int i = 0; i < N; i++) begin
      m_acc[i] = '0;
      m_act[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(acc_flat === '0, "R1 acc", acc_flat[63:0], 64'd0);
    chk(active_flat === '1, "R1 flags", 64'(active_flat), 64'(N'('1)));
    chk(scalar_valid === 1'b0, "R1 valid", 64'(scalar_valid), 64'd0);

    issue(INDEX, 0, 0, 0, 0, "R7 index");
    issue(STORE, 0, 3, 0, 0, "R6 store index");
    idle(1);
    issue(BCAST, 0, 0, 64'h0102_0304_0506_0708, 0, "R7 bcast");
    issue(ADD, 0, 3, 0, 0, "R4 add64");
    issue(BCAST, 0, 0, P, 0, "R7 bcast P");
    issue(STORE, 0, 1, 0, 0, "R6 store P");
    idle(1);
    issue(BCAST, 0, 0, Q, 0, "R7 bcast Q");
    issue(ADD, 2, 1, 0, 0, "R4 add8");
    issue(BCAST, 0, 0, Q, 0, "R7 bcast Q");
    issue(ADD, 1, 1, 0, 0, "R4 add32");
    issue(BCAST, 0, 0, Q, 0, "R7 bcast Q");
    issue(ADD, 0, 1, 0, 0, "R4 add64 carry");
    issue(BCAST, 0, 0, Q, 0, "R7 bcast Q");
    issue(SUB, 2, 1, 0, 0, "R4 sub8");
    issue(BCAST, 0, 0, Q, 0, "R7 bcast Q");
    issue(SUB, 1, 1, 0, 0, "R4 sub32");
    issue(ADD, 5, 1, 0, 0, "R4 fmt other");
    issue(AND_, 0, 1, 0, 0, "R5 and");
    issue(OR_, 0, 3, 0, 0, "R5 or");
    issue(XOR_, 0, 1, 0, 0, "R5 xor");
    ghost();
    issue(LOAD, 0, 3, 0, 0, "R6 load private");
    issue(FETCH, 0, 3, 0, 4, "R11 fetch e4");
    issue(FETCH, 0, 1, 0, 1, "R11 fetch e1");
    issue(FETCH, 0, 1, 0, 7, "R11 fetch out of range");
    idle(2);

    issue(INDEX, 0, 0, 0, 0, "R7 index");
    issue(RTN, 0, 0, 0, 0, "R8 north wrap");
    issue(RTS, 0, 0, 0, 0, "R8 south wrap");
    issue(RTE, 0, 0, 0, 0, "R8 east wrap");
    issue(RTE, 0, 0, 0, 0, "R8 east twice");
    issue(RTW, 0, 0, 0, 0, "R8 west wrap");
    issue(RTN, 0, 0, 0, 0, "R2 back to back");

    issue(BCAST, 0, 0, 64'd7, 0, "R7 bcast 7");
    issue(STORE, 0, 5, 0, 0, "R6 store 7");
    idle(1);
    issue(INDEX, 0, 0, 0, 0, "R7 index");
    issue(ZTEST, 0, 0, 0, 0, "R10 ztest");
    issue(BCAST, 0, 0, 64'hAAAA_AAAA, 0, "R3 masked bcast");
    issue(STORE, 0, 5, 0, 0, "R3 masked store");
    idle(1);
    issue(FETCH, 0, 5, 0, 0, "R11 fetch e0");
    issue(FETCH, 0, 5, 0, 1, "R11 fetch disabled e1");
    issue(ADD, 0, 5, 0, 0, "R3 masked add");
    issue(ENALL, 0, 0, 0, 0, "R10 enall");
    issue(LOAD, 0, 5, 0, 0, "R6 load after mask");

    issue(BCAST, 0, 0, 64'd1, 0, "R7 bcast 1");
    issue(STORE, 0, 2, 0, 0, "R6 store 1");
    idle(1);
    issue(INDEX, 0, 0, 0, 0, "R7 index");
    issue(AND_, 0, 2, 0, 0, "R5 parity");
    issue(ZTEST, 0, 0, 0, 0, "R10 even only");
    issue(BCAST, 0, 0, 64'h55, 0, "R3 even bcast");
    issue(RTE, 0, 0, 0, 0, "R9 masked route east");
    issue(RTN, 0, 0, 0, 0, "R9 masked route north");
    issue(ZTEST, 0, 0, 0, 0, "R10 nested ztest");
    issue(BCAST, 0, 0, 64'h99, 0, "R3 none enabled");
    issue(ENALL, 0, 0, 0, 0, "R10 enall again");
    issue(RTW, 0, 0, 0, 0, "R8 west after enall");
    idle(1);

    while (q.size() > 0) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule